// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is an eight-bit register. A two-bit mode input selects one of four synchronous operations on each rising clock edge: hold, shift toward the most significant bit, shift toward the least significant bit, or load all bits at once. Parallel data enters and leaves through one shared byte-wide bus. That bus is modelled as a separate input vector, an output vector and one output-enable flag, so that a level above can build the real three-state pad. Two active-low enables gate the bus drive. The drive is also withdrawn whenever load mode is selected, so that the bus can act as an input.

Each end of the register has a serial input and a serial output. The serial outputs are always driven. Several instances can therefore be chained into wider words. The least significant bit of a stage feeds the high-end serial input of the stage below it. The most significant bit of a stage feeds the low-end serial input of the stage above it. Feeding the top stage's most significant bit back into the bottom stage's low-end input makes the chain rotate. An active-low clear empties the register at once, with no clock edge needed.

Top module: `ushift_bus`

## Requirements
- R1: While `clr_n` is low, the register is all zeros at once, without waiting for a clock edge, and no other input can change it.
- R2: With `sel` = 2'b00, a clock edge leaves the contents unchanged.
- R3: With `sel` = 2'b01, a clock edge moves every bit n to position n+1 and places `ser_lo_in` in bit 0.
- R4: With `sel` = 2'b10, a clock edge moves every bit n to position n-1 and places `ser_hi_in` in bit 7.
- R5: With `sel` = 2'b11, a clock edge copies `bus_in` into all eight bits, whatever the state of the output enables.
- R6: `bus_oe` is high only when `oe_a_n` and `oe_b_n` are both low and `sel` is not 2'b11. `bus_out` always shows the register contents.
- R7: A high level on either output enable releases the bus. Shifting and loading still go on as selected.
- R8: `ser_lo_out` always equals bit 0 and `ser_hi_out` always equals bit 7, whatever the state of the output enables.
- R9: Two instances chained through their serial pins, with the top bit fed back to the bottom input, rotate a 16-bit word: up by one position in mode 2'b01 and down by one position in mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_lo_in | input | 1 | Serial input that enters bit 0 when shifting up |
| ser_hi_in | input | 1 | Serial input that enters bit 7 when shifting down |
| oe_a_n | input | 1 | Bus output enable, active low |
| oe_b_n | input | 1 | Bus output enable, active low |
| bus_in | input | 8 | Value on the shared bus, used for loading |
| bus_out | output | 8 | Register contents offered to the shared bus |
| bus_oe | output | 1 | High when the block drives the shared bus |
| ser_lo_out | output | 1 | Bit 0, always driven |
| ser_hi_out | output | 1 | Bit 7, always driven |

## Verification
The hardest case to reach from the ports is a multi-stage rotate. There, every bit crosses a stage boundary through a serial pin and comes back through the feedback wire. The bench loads two chained instances with different, asymmetric bytes. It then shifts the pair in both directions for enough edges that the bits cross each boundary. After every edge it compares the 16-bit word with a rotate computed in the bench. The clear is also pulsed in the middle of a cycle while load mode is active, so that it must act before any clock edge and override a pending load.

// File: rtl/ushift_bus.sv
module ushift_bus #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_lo_out,
  output logic             ser_hi_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else begin
      case (sel)
        2'b01:   q <= {q[MSB-1:0], ser_lo_in};
        2'b10:   q <= {ser_hi_in, q[MSB:1]};
        2'b11:   q <= bus_in;
        default: q <= q;
      endcase
    end
  end

  assign bus_out    = q;
  assign bus_oe     = !oe_a_n && !oe_b_n && (sel != 2'b11);
  assign ser_lo_out = q[0];
  assign ser_hi_out = q[MSB];

  assert_clear_R1: assert property (@(posedge clk) !clr_n |-> bus_out == '0);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b00) |=> $stable(bus_out));
  assert_up_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b01) |=> bus_out == {$past(bus_out[MSB-1:0]), $past(ser_lo_in)});
  assert_down_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b10) |=> bus_out == {$past(ser_hi_in), $past(bus_out[MSB:1])});
  assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b11) |=> bus_out == $past(bus_in));
  assert_release_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n || sel == 2'b11) |-> !bus_oe);
endmodule

// File: tb/test_ushift_bus.sv
module test_ushift_bus;
  logic       clk = 1'b0;
  logic       clr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       lo_in = 1'b0, hi_in = 1'b0, cascade = 1'b0;
  logic       oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [7:0] bin_a = 8'h00, bin_b = 8'h00;
  logic [7:0] out_a, out_b;
  logic       oe_a, oe_b, a_lo, a_hi, b_lo, b_hi;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ushift_bus #(.WIDTH(8)) i_ushift_bus (
    .clk(clk), .clr_n(clr_n), .sel(sel),
    .ser_lo_in(cascade ? b_hi : lo_in), .ser_hi_in(cascade ? b_lo : hi_in),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin_a),
    .bus_out(out_a), .bus_oe(oe_a), .ser_lo_out(a_lo), .ser_hi_out(a_hi));

  ushift_bus #(.WIDTH(8)) i_ushift_bus_up (
    .clk(clk), .clr_n(clr_n), .sel(sel),
    .ser_lo_in(cascade ? a_hi : 1'b0), .ser_hi_in(cascade ? a_lo : 1'b0),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin_b),
    .bus_out(out_b), .bus_oe(oe_b), .ser_lo_out(b_lo), .ser_hi_out(b_hi));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset contents", out_a, 0);
    chk("R8 reset ends", {a_hi, a_lo}, 0);
    chk("R6 drive in hold", oe_a, 1);
  endtask

  task automatic t_load();
    sel = 2'b11; bin_a = 8'hC6; oe_a_n = 1'b0; oe_b_n = 1'b0;
    #1 chk("R6 load releases bus", oe_a, 0);
    edge1();
    chk("R5 load", out_a, 8'hC6);
    oe_a_n = 1'b1; oe_b_n = 1'b1; bin_a = 8'h39;
    edge1();
    chk("R5 load with enables high", out_a, 8'h39);
    oe_a_n = 1'b0; oe_b_n = 1'b0;
  endtask

  task automatic t_hold();
    sel = 2'b00; bin_a = 8'hFF; lo_in = 1'b1; hi_in = 1'b1;
    for (int i = 0; i < 3; i++) edge1();
    chk("R2 hold", out_a, 8'h39);
    #1 chk("R6 drive in hold", oe_a, 1);
  endtask

  task automatic t_up();
    logic [7:0] exp = 8'h39;
    logic [4:0] pat = 5'b10110;
    sel = 2'b01;
    for (int i = 0; i < 5; i++) begin
      lo_in = pat[i];
      exp = {exp[6:0], pat[i]};
      edge1();
      chk("R3 shift up", out_a, exp);
    end
  endtask

  task automatic t_down();
    logic [7:0] exp = out_a;
    logic [5:0] pat = 6'b011001;
    sel = 2'b10;
    for (int i = 0; i < 6; i++) begin
      hi_in = pat[i];
      exp = {pat[i], exp[7:1]};
      edge1();
      chk("R4 shift down", out_a, exp);
    end
  endtask

  task automatic t_enables();
    logic [7:0] exp;
    sel = 2'b11; bin_a = 8'h81; edge1();
    oe_b_n = 1'b1; sel = 2'b01; lo_in = 1'b0;
    #1 chk("R6 enable b releases", oe_a, 0);
    edge1();
    exp = 8'h02;
    chk("R7 shift while released", out_a, exp);
    chk("R8 ends while released", {a_hi, a_lo}, {exp[7], exp[0]});
    oe_b_n = 1'b0; oe_a_n = 1'b1; sel = 2'b10; hi_in = 1'b1;
    #1 chk("R6 enable a releases", oe_a, 0);
    edge1();
    exp = 8'h81;
    chk("R7 shift down while released", out_a, exp);
    chk("R8 ends while released", {a_hi, a_lo}, {exp[7], exp[0]});
    oe_a_n = 1'b0; sel = 2'b00;
    #1 chk("R6 drive restored", oe_a, 1);
  endtask

  task automatic t_clear();
    sel = 2'b11; bin_a = 8'h5A;
    @(posedge clk); #1;
    clr_n = 1'b0;
    #1 chk("R1 clear before edge", out_a, 0);
    @(posedge clk); #1;
    chk("R1 clear overrides load", out_a, 0);
    @(negedge clk) clr_n = 1'b1;
    sel = 2'b00;
    edge1();
    chk("R1 after release", out_a, 0);
  endtask

  task automatic t_cascade();
    logic [15:0] w = 16'h3CA5;
    sel = 2'b11; bin_a = w[7:0]; bin_b = w[15:8];
    edge1();
    cascade = 1'b1; sel = 2'b01;
    for (int i = 0; i < 10; i++) begin
      w = {w[14:0], w[15]};
      edge1();
      chk("R9 rotate up", {out_b, out_a}, w);
    end
    sel = 2'b10;
    for (int i = 0; i < 11; i++) begin
      w = {w[0], w[15:1]};
      edge1();
      chk("R9 rotate down", {out_b, out_a}, w);
    end
    cascade = 1'b0; sel = 2'b00;
  endtask

  initial begin
    #3 clr_n = 1'b0;
    #10 clr_n = 1'b1;
    t_reset();
    t_load();
    t_hold();
    t_up();
    t_down();
    t_enables();
    t_clear();
    t_cascade();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule